// File: doc/BRIEF.md
# Diagonal Round-Robin Crossbar Scheduler

This block is the decision and switching core of a four-port switch with queues at its inputs. Every input port reports which of its per-destination queues hold a packet, in two priority classes. On a capture edge the core picks one diagonal. A diagonal is a fixed one-to-one pairing of inputs with outputs, so no input sends twice and no output receives twice. The core then pulses a dequeue grant to every input whose queue on that pairing is ready. The granted inputs present their head packets, and on the next edge a crossbar registers those packets onto the outputs with valid flags.

The core runs on a clock at twice the port rate. Captures happen on even edges and output updates on odd edges, which forms a two-stage pipeline: new requests are judged while the previous winners are being sent. Diagonal `d` joins input `i` to output `(i + d) mod 4`. The search starts at a rotating pointer. It looks first for any diagonal carrying a high-priority request, and only if there is none does it look for low-priority ones. Each forwarded packet has its routing field shifted up by two bits, which exposes the next hop's destination for source routing.

Top module: `drr_sched_core`

## Requirements
- R1: After reset `cap_phase` is 1, `deq_grant` is 0 and every `out_valid` and `out_pkt` bit is 0. After that, `cap_phase` inverts on every rising clock edge. An edge at which `cap_phase` was 1 is a capture edge, and the edge that follows it is an output edge.
- R2: Requests are sampled only at capture edges. The resulting `deq_grant` is visible for exactly the one cycle after the capture edge and is cleared at the output edge.
- R3: Request flag bit `i*4 + o` of `req_hi` or `req_lo` means input `i` holds a packet for output `o`. With winning diagonal `d` and the winning class, `deq_grant[i]` is 1 exactly when the flag for input `i` and output `(i+d) mod 4` is set in that class. `diag_sel` shows `d`.
- R4: If any high-priority flag is set at a capture edge, the winner is a diagonal that has a high-priority flag and `deq_pri` is 1. Low-priority flags are used, with `deq_pri` 0, only when no high-priority flag is set.
- R5: The search examines diagonals `ptr, ptr+1, ...` modulo 4, and `ptr` is 0 after reset. After a grant on diagonal `d`, `ptr` becomes `(d+1) mod 4`. A capture edge with no request leaves `ptr` unchanged.
- R6: At the output edge, `out_valid[j]` becomes 1 exactly when input `(j-d) mod 4` was granted. `out_pkt[10*j +: 10]` then carries that input's `in_pkt[10*i +: 10]`, with the payload in bits [3:0] unchanged and the routing field in bits [9:4] shifted left by 2 with zero fill. An output with no packet shows all zeros. Outputs hold their value across the following capture edge.
- R7: A capture edge with no request flag set issues no grant, and every `out_valid` is 0 after the following output edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the port rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_hi | input | 16 | High-priority queue-ready flags, bit i*4+o |
| req_lo | input | 16 | Low-priority queue-ready flags, bit i*4+o |
| in_pkt | input | 40 | Head packet of the granted queue per input, 10 bits each |
| cap_phase | output | 1 | 1 when the next rising edge is a capture edge |
| deq_grant | output | 4 | One-cycle dequeue pulse per input |
| deq_pri | output | 1 | Class of the last grant, 1 = high |
| diag_sel | output | 2 | Diagonal of the last grant |
| out_valid | output | 4 | Packet present per output |
| out_pkt | output | 40 | Forwarded packet per output, 10 bits each |

## Verification
A request applied while `cap_phase` is 1 yields its grant, priority and diagonal one edge later. The packets it moves appear on the outputs one further edge later, two edges after the request. The bench drives inputs and reads results at falling edges. It checks grants at the falling edge right after the capture edge and outputs at the falling edge right after the output edge. It also checks once more after the next capture edge to confirm that the outputs hold. A reference model in the bench keeps its own pointer and predicts the winner and every output lane.

// File: rtl/drr_pkg.sv
package drr_pkg;
   // output lane that input src reaches on diagonal diag
   function automatic int diag_dst(int src, int diag, int n);
      return (src + diag) % n;
   endfunction
   // input lane that feeds output dst on diagonal diag
   function automatic int diag_src(int dst, int diag, int n);
      return (dst - diag + n) % n;
   endfunction
endpackage

// File: rtl/drr_diag_pick.sv
module drr_diag_pick #(
   parameter int N = 4
) (
   input  logic [N*N-1:0]       req_hi,
   input  logic [N*N-1:0]       req_lo,
   input  logic [$clog2(N)-1:0] ptr,
   output logic                 found,
   output logic                 win_hi,
   output logic [$clog2(N)-1:0] win_diag,
   output logic [N-1:0]         win_mask
);
   import drr_pkg::*;
   localparam int DW = $clog2(N);

   logic [N-1:0] any_hi, any_lo;

   for (genvar d = 0; d < N; d++) begin : g_diag
      logic [N-1:0] hv, lv;
      for (genvar i = 0; i < N; i++) begin : g_in
         assign hv[i] = req_hi[i*N + ((i + d) % N)];
         assign lv[i] = req_lo[i*N + ((i + d) % N)];
      end
      assign any_hi[d] = |hv;
      assign any_lo[d] = |lv;
   end

   // downward scan: nearest diagonal to ptr wins; high class overrides low
   always_comb begin
      found    = 1'b0;
      win_hi   = 1'b0;
      win_diag = ptr;
      for (int k = N - 1; k >= 0; k--) begin
         if (any_lo[(int'(ptr) + k) % N]) begin
            found    = 1'b1;
            win_diag = DW'((int'(ptr) + k) % N);
         end
      end
      for (int k = N - 1; k >= 0; k--) begin
         if (any_hi[(int'(ptr) + k) % N]) begin
            found    = 1'b1;
            win_hi   = 1'b1;
            win_diag = DW'((int'(ptr) + k) % N);
         end
      end
   end

   always_comb begin
      for (int i = 0; i < N; i++) begin
         win_mask[i] = win_hi ? req_hi[i*N + diag_dst(i, int'(win_diag), N)]
                              : req_lo[i*N + diag_dst(i, int'(win_diag), N)];
      end
   end
endmodule

// File: rtl/drr_xbar.sv
module drr_xbar #(
   parameter int N     = 4,
   parameter int PAY_W = 4,
   parameter int RT_W  = 6
) (
   input  logic [N*(PAY_W+RT_W)-1:0] src_pkt,
   input  logic [N-1:0]              src_vld,
   input  logic [$clog2(N)-1:0]      diag,
   output logic [N*(PAY_W+RT_W)-1:0] dst_pkt,
   output logic [N-1:0]              dst_vld
);
   import drr_pkg::*;
   localparam int PKT_W = PAY_W + RT_W;
   localparam int DW    = $clog2(N);

   for (genvar j = 0; j < N; j++) begin : g_out
      logic [PKT_W-1:0] pick;
      logic             v;
      logic [RT_W-1:0]  rt_fwd;
      always_comb begin
         pick = '0;
         v    = 1'b0;
         for (int i = 0; i < N; i++) begin
            if (diag_src(j, int'(diag), N) == i) begin
               pick = src_pkt[i*PKT_W +: PKT_W];
               v    = src_vld[i];
            end
         end
      end
      // next hop moves into the top routing bits
      assign rt_fwd     = pick[PKT_W-1:PAY_W] << DW;
      assign dst_vld[j] = v;
      assign dst_pkt[j*PKT_W +: PKT_W] = v ? {rt_fwd, pick[PAY_W-1:0]} : '0;
   end
endmodule

// File: rtl/drr_sched_core.sv
module drr_sched_core #(
   parameter int N     = 4,
   parameter int PAY_W = 4,
   parameter int RT_W  = 6
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [N*N-1:0]            req_hi,
   input  logic [N*N-1:0]            req_lo,
   input  logic [N*(PAY_W+RT_W)-1:0] in_pkt,
   output logic                      cap_phase,
   output logic [N-1:0]              deq_grant,
   output logic                      deq_pri,
   output logic [$clog2(N)-1:0]      diag_sel,
   output logic [N-1:0]              out_valid,
   output logic [N*(PAY_W+RT_W)-1:0] out_pkt
);
   localparam int DW    = $clog2(N);
   localparam int PKT_W = PAY_W + RT_W;

   if (N < 2 || N != (1 << DW)) begin : g_bad_n
      $error("drr_sched_core: N must be a power of two, at least 2");
   end
   if (RT_W < DW) begin : g_bad_rt
      $error("drr_sched_core: routing field narrower than one hop");
   end
   if (PAY_W < 1) begin : g_bad_pay
      $error("drr_sched_core: payload width must be positive");
   end

   logic             ph_q;
   logic [DW-1:0]    ptr_q, diag_q;
   logic [N-1:0]     grant_q, ov_q;
   logic             pri_q;
   logic [N*PKT_W-1:0] op_q;

   logic             found, win_hi;
   logic [DW-1:0]    win_diag;
   logic [N-1:0]     win_mask, x_vld;
   logic [N*PKT_W-1:0] x_pkt;

   drr_diag_pick #(.N(N)) u_pick (
      .req_hi   (req_hi),
      .req_lo   (req_lo),
      .ptr      (ptr_q),
      .found    (found),
      .win_hi   (win_hi),
      .win_diag (win_diag),
      .win_mask (win_mask)
   );

   drr_xbar #(.N(N), .PAY_W(PAY_W), .RT_W(RT_W)) u_xbar (
      .src_pkt (in_pkt),
      .src_vld (grant_q),
      .diag    (diag_q),
      .dst_pkt (x_pkt),
      .dst_vld (x_vld)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q    <= 1'b1;
         ptr_q   <= '0;
         diag_q  <= '0;
         pri_q   <= 1'b0;
         grant_q <= '0;
         ov_q    <= '0;
         op_q    <= '0;
      end else begin
         ph_q <= ~ph_q;
         if (ph_q) begin
            grant_q <= found ? win_mask : '0;
            if (found) begin
               diag_q <= win_diag;
               pri_q  <= win_hi;
               ptr_q  <= win_diag + 1'b1;
            end
         end else begin
            grant_q <= '0;
            ov_q    <= x_vld;
            op_q    <= x_pkt;
         end
      end
   end

   assign cap_phase = ph_q;
   assign deq_grant = grant_q;
   assign deq_pri   = pri_q;
   assign diag_sel  = diag_q;
   assign out_valid = ov_q;
   assign out_pkt   = op_q;

   AST_PHASE_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> (ph_q != $past(ph_q)));                                   // R1
   AST_GRANT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      (|grant_q) |=> (grant_q == '0));                                    // R2
   AST_HIGH_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      ((|grant_q) && !pri_q) |-> ($past(req_hi) == '0));                  // R4
   AST_IDLE_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(ph_q) && ($past(req_hi | req_lo) == '0)) |-> (grant_q == '0)); // R7
   AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      ph_q |=> ($stable(ov_q) && $stable(op_q)));                         // R6
   AST_VALID_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      !ph_q |=> ($countones(ov_q) == $countones($past(grant_q))));        // R6
endmodule

// File: tb/drr_sched_core_tb.sv
module drr_sched_core_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] req_hi = '0, req_lo = '0;
   logic [39:0] in_pkt = '0;
   logic        cap_phase, deq_pri;
   logic [3:0]  deq_grant, out_valid;
   logic [1:0]  diag_sel;
   logic [39:0] out_pkt;

   int checks = 0, errors = 0;
   int ptr_m = 0;

   always #10 clk = ~clk;

   drr_sched_core u_dut (
      .clk(clk), .rst_n(rst_n), .req_hi(req_hi), .req_lo(req_lo), .in_pkt(in_pkt),
      .cap_phase(cap_phase), .deq_grant(deq_grant), .deq_pri(deq_pri),
      .diag_sel(diag_sel), .out_valid(out_valid), .out_pkt(out_pkt)
   );

   task automatic chk(string rq, string what, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
      end
   endtask

   function automatic logic [39:0] mk_pkts(int base);
      logic [39:0] p;
      for (int i = 0; i < 4; i++) p[i*10 +: 10] = {6'(base + i*13 + 5), 4'(base + i + 9)};
      return p;
   endfunction

   // one scheduling slot: drive, check grant, check outputs (and optionally the hold)
   task automatic run_slot(string rq, logic [15:0] h, logic [15:0] l, int base, bit hold);
      bit f = 0, hi = 0;
      int d = 0;
      logic [3:0] m = '0;
      logic [39:0] pk, exp_o;
      logic [3:0] exp_v;
      while (cap_phase !== 1'b1) @(negedge clk);
      pk = mk_pkts(base);
      req_hi = h; req_lo = l; in_pkt = pk;
      for (int k = 0; k < 4; k++) begin
         int dd = (ptr_m + k) % 4;
         for (int i = 0; i < 4; i++)
            if (!f && h[i*4 + (i+dd)%4]) begin f = 1; hi = 1; d = dd; end
      end
      for (int k = 0; k < 4; k++) begin
         int dd = (ptr_m + k) % 4;
         for (int i = 0; i < 4; i++)
            if (!f && l[i*4 + (i+dd)%4]) begin f = 1; d = dd; end
      end
      if (f) for (int i = 0; i < 4; i++) m[i] = hi ? h[i*4 + (i+d)%4] : l[i*4 + (i+d)%4];
      exp_v = '0; exp_o = '0;
      for (int j = 0; j < 4; j++) begin
         int i = (j - d + 4) % 4;
         if (m[i]) begin
            exp_v[j] = 1'b1;
            exp_o[j*10 +: 10] = {pk[i*10+4 +: 6] << 2, pk[i*10 +: 4]};
         end
      end
      @(negedge clk);
      chk({rq, " R2 R3"}, "deq_grant", 64'(deq_grant), 64'(m));
      if (f) begin
         chk({rq, " R4"}, "deq_pri", 64'(deq_pri), 64'(hi));
         chk({rq, " R5"}, "diag_sel", 64'(diag_sel), 64'(d));
         ptr_m = (d + 1) % 4;
      end
      req_hi = '0; req_lo = '0;
      @(negedge clk);
      chk({rq, " R2"}, "deq_grant cleared", 64'(deq_grant), 64'h0);
      chk({rq, " R6"}, "out_valid", 64'(out_valid), 64'(exp_v));
      chk({rq, " R6"}, "out_pkt", 64'(out_pkt), 64'(exp_o));
      if (hold) begin
         @(negedge clk);
         chk({rq, " R6 hold"}, "out_valid", 64'(out_valid), 64'(exp_v));
         chk({rq, " R6 hold"}, "out_pkt", 64'(out_pkt), 64'(exp_o));
      end
   endtask

   task automatic t_reset();
      chk("R1", "cap_phase", 64'(cap_phase), 64'h1);
      chk("R1", "deq_grant", 64'(deq_grant), 64'h0);
      chk("R1", "out_valid", 64'(out_valid), 64'h0);
      chk("R1", "out_pkt", 64'(out_pkt), 64'h0);
      @(negedge clk);
      chk("R1 toggle", "cap_phase", 64'(cap_phase), 64'h0);
      @(negedge clk);
      chk("R1 toggle", "cap_phase", 64'(cap_phase), 64'h1);
   endtask

   task automatic t_single();   // input0 -> output2, diagonal 2
      run_slot("single", 16'h0004, 16'h0000, 1, 1'b1);
   endtask
   task automatic t_priority(); // low on diag3 at pointer, high on diag1
      run_slot("priority", 16'h0800, 16'h0010, 20, 1'b0);
   endtask
   task automatic t_round_robin();
      for (int r = 0; r < 4; r++) run_slot("round-robin R3 R5", 16'hFFFF, 16'h0000, 40 + r, 1'b0);
   endtask
   task automatic t_idle();
      run_slot("idle R7", 16'h0000, 16'h0000, 60, 1'b1);
   endtask
   task automatic t_low_partial(); // low on diag2 (in1,in3) and diag0 (in0,in2)
      run_slot("low-partial R5", 16'h0000, 16'h2481, 70, 1'b0);
      run_slot("low-partial R5", 16'h0000, 16'h2481, 80, 1'b0);
   endtask

   initial begin
      #(200000 * 20);
      errors++; checks++;
      $display("FAIL watchdog R1 actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_single();
      t_priority();
      t_round_robin();
      t_idle();
      t_low_partial();
      repeat (2) @(negedge clk);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule